// File: doc/BRIEF.md
# Firmware Image Loader Engine

This engine takes a packed firmware image held in byte-wide memory and turns it into a sequence of register writes that bring up one or more embedded processors. It reads the image through a synchronous byte read port with one cycle of latency. It validates the image header, optionally compares the image's target device against the configured device, and then walks one fixed-size descriptor per processor, issuing writes on a simple register write bus.

Every multi-byte field in the image is big-endian. The header begins with a 32-bit total length at byte 0, which covers all microcode and the trailing 32-bit check word. Byte 4 starts a three-byte tag. Byte 7 holds a version, which the engine ignores. Bytes 8-9 hold a 16-bit device model, byte 10 the major revision, byte 11 the minor revision and byte 12 the descriptor count. Descriptors start at byte 16 and are `4*NUM_TRAPS+16` bytes apart. Within a descriptor, the trap words sit at offsets `4*i`. After them come the error-control word, the instruction-RAM start address, the word count, and the byte offset of the microcode measured from the image start. The check-word computation lives in a separate block.

A load is started with a one-cycle `start` pulse. It ends with a one-cycle `done` pulse or a one-cycle `fail` pulse. On failure, `err_code` keeps its value until the next start.

Top module: `fw_image_loader`

## Requirements
- R1: Multi-byte image fields are assembled most-significant byte first, and microcode words reach `wr_data` in that byte order.
- R2: If bytes 4..6 are not 0x51, 0x45, 0x46, the load fails with `err_code` 1 and no register write is issued.
- R3: A model field of 0 skips device matching. Any other model must equal `cfg_model`, and the revision bytes must equal `cfg_major` and `cfg_minor`; otherwise the load fails with `err_code` 2 and no write is issued.
- R4: A descriptor count of 0 or above `MAX_PROC` fails with `err_code` 4 and no write is issued.
- R5: A good load writes in this order: reset register 0x00 with data 1; then split register 0x01; then, for each descriptor in turn, its microcode, its traps and its error-control word (register 0x04). Writes occur only while `busy` is high.
- R6: The split register receives 1 when the count is above 1 and 0 otherwise.
- R7: Trap i of a descriptor is written unchanged to register 0x10+i, in index order, and only when it is non-zero.
- R8: For descriptor p, `wr_proc` equals p. The start address is written to register 0x02, then word k is read from byte offset+4k and written to register 0x03, for k = 0..count-1. A count of zero gives no 0x03 writes.
- R9: Once the length is known, the engine never reads at an address equal to or above it. A read that would reach it fails the load with `err_code` 3, and no further writes follow.
- R10: `done` (success) or `fail` (error) pulses for exactly one cycle. `done` comes the cycle after the last write, and the two are never high together. After reset, `busy`, `done`, `fail`, `wr_en` and `err_code` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load (ignored while busy) |
| cfg_model | input | 16 | Configured device model |
| cfg_major | input | 8 | Configured major revision |
| cfg_minor | input | 8 | Configured minor revision |
| img_rd_en | output | 1 | Image byte read request |
| img_addr | output | ADDR_W | Image byte address |
| img_rdata | input | 8 | Image byte, valid the cycle after the request |
| wr_en | output | 1 | Register write strobe |
| wr_proc | output | PROC_W | Target processor index |
| wr_reg | output | 8 | Register select (0x00 reset, 0x01 split, 0x02 address, 0x03 data, 0x04 error control, 0x10+i trap i) |
| wr_data | output | 32 | Register write data |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |
| err_code | output | 3 | 0 none, 1 tag, 2 device, 3 bounds, 4 count |

## Verification
The assertions check the following on every cycle:
- trap writes never carry zero;
- the split write directly follows the reset write and holds a single bit;
- no image read reaches the recorded length;
- writes happen only while busy;
- `done` and `fail` are single-cycle pulses that never coincide.

Only the bench's scenarios can show the rest:
- the full content and order of the write stream, and the byte order of each word;
- that validation failures produce no writes at all;
- that a bounds error leaves exactly the expected prefix of writes.

// File: rtl/fwl_pkg.sv
package fwl_pkg;

  localparam int unsigned HDR_BYTES = 16;
  localparam logic [23:0] TAG_QEF   = 24'h514546;

  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_TAG    = 3'd1,
    ERR_DEVICE = 3'd2,
    ERR_BOUNDS = 3'd3,
    ERR_COUNT  = 3'd4
  } err_e;

  localparam logic [7:0] REG_RESET = 8'h00;
  localparam logic [7:0] REG_SPLIT = 8'h01;
  localparam logic [7:0] REG_IADDR = 8'h02;
  localparam logic [7:0] REG_IDATA = 8'h03;
  localparam logic [7:0] REG_ECTL  = 8'h04;
  localparam logic [7:0] REG_TRAP0 = 8'h10;

  // big-endian accumulation: older bytes move up
  function automatic logic [31:0] be_push(logic [23:0] acc, logic [7:0] b);
    return {acc, b};
  endfunction

  function automatic logic [31:0] desc_stride(int unsigned ntraps);
    return 32'(4 * ntraps + 16);
  endfunction

  function automatic logic [31:0] desc_base(logic [7:0] proc, int unsigned ntraps);
    return 32'(HDR_BYTES) + 32'(proc) * desc_stride(ntraps);
  endfunction

  function automatic logic device_ok(logic [31:0] fld, logic [15:0] model,
                                     logic [7:0] major, logic [7:0] minor);
    return (fld[31:16] == 16'h0000) ||
           ((fld[31:16] == model) && (fld[15:8] == major) && (fld[7:0] == minor));
  endfunction

endpackage

// File: rtl/fwl_byte_fetch.sv
module fwl_byte_fetch #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       addr,
  input  logic [2:0]        nbytes,
  input  logic [31:0]       limit,
  input  logic              limit_ok,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rdata,
  output logic              done,
  output logic              oob,
  output logic [31:0]       value
);
  import fwl_pkg::*;

  logic        active_q, pend_q;
  logic [2:0]  n_q, iss_q, rcv_q;
  logic [31:0] base_q;
  logic [23:0] acc_q;
  logic [31:0] cur_addr;
  logic        issuing;

  assign cur_addr = base_q + 32'(iss_q);
  assign issuing  = active_q && (iss_q < n_q);
  assign oob      = issuing && limit_ok && (cur_addr >= limit);
  assign rd_en    = issuing && !oob;
  assign rd_addr  = cur_addr[ADDR_W-1:0];
  assign value    = be_push(acc_q, rdata);
  assign done     = pend_q && active_q && (rcv_q == n_q - 3'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      n_q      <= '0;
      iss_q    <= '0;
      rcv_q    <= '0;
      base_q   <= '0;
      acc_q    <= '0;
    end else begin
      pend_q <= rd_en;
      if (start) begin
        active_q <= 1'b1;
        base_q   <= addr;
        n_q      <= nbytes;
        iss_q    <= '0;
        rcv_q    <= '0;
        acc_q    <= '0;
      end else begin
        if (rd_en) iss_q <= iss_q + 3'd1;
        if (pend_q) begin
          acc_q <= value[23:0];
          rcv_q <= rcv_q + 3'd1;
        end
        if (oob || done) active_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fwl_seq.sv
module fwl_seq #(
  parameter int MAX_PROC  = 2,
  parameter int NUM_TRAPS = 16,
  parameter int PROC_W    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       cfg_model,
  input  logic [7:0]        cfg_major,
  input  logic [7:0]        cfg_minor,
  output logic              f_start,
  output logic [31:0]       f_addr,
  output logic [2:0]        f_nbytes,
  input  logic              f_done,
  input  logic              f_oob,
  input  logic [31:0]       f_value,
  output logic [31:0]       limit,
  output logic              limit_ok,
  output logic              wr_en,
  output logic [PROC_W-1:0] wr_proc,
  output logic [7:0]        wr_reg,
  output logic [31:0]       wr_data,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [2:0]        err_code
);
  import fwl_pkg::*;

  localparam int TRAP_W = (NUM_TRAPS > 1) ? $clog2(NUM_TRAPS) : 1;
  localparam logic [31:0] OFF_ECTL = 32'(4 * NUM_TRAPS);
  localparam logic [31:0] OFF_IOFF = OFF_ECTL + 32'd4;
  localparam logic [31:0] OFF_WCNT = OFF_ECTL + 32'd8;
  localparam logic [31:0] OFF_COFF = OFF_ECTL + 32'd12;
  localparam logic [TRAP_W-1:0] LAST_TRAP = TRAP_W'(NUM_TRAPS - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_LEN, S_TAG, S_DEV, S_CNT, S_RST, S_SPLIT,
    S_WCNT, S_COFF, S_IOFF, S_WORD, S_TRAP, S_ECTL, S_FIN
  } state_e;

  state_e            state_q;
  logic              wait_q;
  logic [31:0]       len_q;
  logic              len_ok_q;
  logic [7:0]        cnt_q, proc_q;
  logic [31:0]       wcnt_q, coff_q, idx_q;
  logic [TRAP_W-1:0] trap_q;
  err_e              err_q;
  logic [31:0]       dbase;
  logic              fetching;

  assign dbase    = desc_base(proc_q, NUM_TRAPS);
  assign limit    = len_q;
  assign limit_ok = len_ok_q;
  assign busy     = (state_q != S_IDLE);
  assign err_code = err_q;

  always_comb begin
    fetching = 1'b1;
    f_addr   = '0;
    f_nbytes = 3'd4;
    unique case (state_q)
      S_LEN:  f_addr = 32'd0;
      S_TAG:  begin f_addr = 32'd4; f_nbytes = 3'd3; end
      S_DEV:  f_addr = 32'd8;
      S_CNT:  begin f_addr = 32'd12; f_nbytes = 3'd1; end
      S_WCNT: f_addr = dbase + OFF_WCNT;
      S_COFF: f_addr = dbase + OFF_COFF;
      S_IOFF: f_addr = dbase + OFF_IOFF;
      S_WORD: f_addr = coff_q + (idx_q << 2);
      S_TRAP: f_addr = dbase + (32'(trap_q) << 2);
      S_ECTL: f_addr = dbase + OFF_ECTL;
      default: fetching = 1'b0;
    endcase
    f_start = fetching && !wait_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      wait_q   <= 1'b0;
      len_q    <= '0;
      len_ok_q <= 1'b0;
      cnt_q    <= '0;
      proc_q   <= '0;
      wcnt_q   <= '0;
      coff_q   <= '0;
      idx_q    <= '0;
      trap_q   <= '0;
      err_q    <= ERR_NONE;
      wr_en    <= 1'b0;
      wr_proc  <= '0;
      wr_reg   <= '0;
      wr_data  <= '0;
      done     <= 1'b0;
      fail     <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      fail  <= 1'b0;
      if (f_start) wait_q <= 1'b1;
      if (f_oob) begin
        wait_q  <= 1'b0;
        err_q   <= ERR_BOUNDS;
        fail    <= 1'b1;
        state_q <= S_IDLE;
      end else if (f_done && wait_q) begin
        wait_q <= 1'b0;
        unique case (state_q)
          S_LEN: begin
            len_q    <= f_value;
            len_ok_q <= 1'b1;
            state_q  <= S_TAG;
          end
          S_TAG: begin
            if (f_value[23:0] == TAG_QEF) state_q <= S_DEV;
            else begin err_q <= ERR_TAG; fail <= 1'b1; state_q <= S_IDLE; end
          end
          S_DEV: begin
            if (device_ok(f_value, cfg_model, cfg_major, cfg_minor)) state_q <= S_CNT;
            else begin err_q <= ERR_DEVICE; fail <= 1'b1; state_q <= S_IDLE; end
          end
          S_CNT: begin
            if (f_value == 32'd0 || f_value > 32'(MAX_PROC)) begin
              err_q <= ERR_COUNT; fail <= 1'b1; state_q <= S_IDLE;
            end else begin
              cnt_q   <= f_value[7:0];
              state_q <= S_RST;
            end
          end
          S_WCNT: begin wcnt_q <= f_value; state_q <= S_COFF; end
          S_COFF: begin coff_q <= f_value; state_q <= S_IOFF; end
          S_IOFF: begin
            wr_en   <= 1'b1;
            wr_proc <= proc_q[PROC_W-1:0];
            wr_reg  <= REG_IADDR;
            wr_data <= f_value;
            idx_q   <= '0;
            trap_q  <= '0;
            state_q <= (wcnt_q == 32'd0) ? S_TRAP : S_WORD;
          end
          S_WORD: begin
            wr_en   <= 1'b1;
            wr_proc <= proc_q[PROC_W-1:0];
            wr_reg  <= REG_IDATA;
            wr_data <= f_value;
            idx_q   <= idx_q + 32'd1;
            if (idx_q + 32'd1 == wcnt_q) state_q <= S_TRAP;
          end
          S_TRAP: begin
            if (f_value != 32'd0) begin
              wr_en   <= 1'b1;
              wr_proc <= proc_q[PROC_W-1:0];
              wr_reg  <= REG_TRAP0 + 8'(trap_q);
              wr_data <= f_value;
            end
            trap_q <= trap_q + 1'b1;
            if (trap_q == LAST_TRAP) state_q <= S_ECTL;
          end
          S_ECTL: begin
            wr_en   <= 1'b1;
            wr_proc <= proc_q[PROC_W-1:0];
            wr_reg  <= REG_ECTL;
            wr_data <= f_value;
            if (proc_q + 8'd1 == cnt_q) state_q <= S_FIN;
            else begin
              proc_q  <= proc_q + 8'd1;
              state_q <= S_WCNT;
            end
          end
          default: state_q <= state_q;
        endcase
      end else begin
        unique case (state_q)
          S_IDLE: if (start) begin
            err_q    <= ERR_NONE;
            len_ok_q <= 1'b0;
            proc_q   <= '0;
            state_q  <= S_LEN;
          end
          S_RST: begin
            wr_en   <= 1'b1;
            wr_proc <= '0;
            wr_reg  <= REG_RESET;
            wr_data <= 32'd1;
            state_q <= S_SPLIT;
          end
          S_SPLIT: begin
            wr_en   <= 1'b1;
            wr_proc <= '0;
            wr_reg  <= REG_SPLIT;
            wr_data <= {31'd0, (cnt_q > 8'd1)};
            proc_q  <= '0;
            state_q <= S_WCNT;
          end
          S_FIN: begin
            done    <= 1'b1;
            state_q <= S_IDLE;
          end
          default: state_q <= state_q;
        endcase
      end
    end
  end

endmodule

// File: rtl/fw_image_loader.sv
module fw_image_loader #(
  parameter int ADDR_W    = 16,
  parameter int MAX_PROC  = 2,
  parameter int NUM_TRAPS = 16,
  localparam int PROC_W   = (MAX_PROC > 1) ? $clog2(MAX_PROC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       cfg_model,
  input  logic [7:0]        cfg_major,
  input  logic [7:0]        cfg_minor,
  output logic              img_rd_en,
  output logic [ADDR_W-1:0] img_addr,
  input  logic [7:0]        img_rdata,
  output logic              wr_en,
  output logic [PROC_W-1:0] wr_proc,
  output logic [7:0]        wr_reg,
  output logic [31:0]       wr_data,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [2:0]        err_code
);

  logic        f_start, f_done, f_oob;
  logic [31:0] f_addr, f_value;
  logic [2:0]  f_nbytes;
  logic [31:0] img_limit;
  logic        limit_ok;

  fwl_byte_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (f_start),
    .addr     (f_addr),
    .nbytes   (f_nbytes),
    .limit    (img_limit),
    .limit_ok (limit_ok),
    .rd_en    (img_rd_en),
    .rd_addr  (img_addr),
    .rdata    (img_rdata),
    .done     (f_done),
    .oob      (f_oob),
    .value    (f_value)
  );

  fwl_seq #(.MAX_PROC(MAX_PROC), .NUM_TRAPS(NUM_TRAPS), .PROC_W(PROC_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfg_model (cfg_model),
    .cfg_major (cfg_major),
    .cfg_minor (cfg_minor),
    .f_start   (f_start),
    .f_addr    (f_addr),
    .f_nbytes  (f_nbytes),
    .f_done    (f_done),
    .f_oob     (f_oob),
    .f_value   (f_value),
    .limit     (img_limit),
    .limit_ok  (limit_ok),
    .wr_en     (wr_en),
    .wr_proc   (wr_proc),
    .wr_reg    (wr_reg),
    .wr_data   (wr_data),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .err_code  (err_code)
  );

endmodule

// File: rtl/fwl_checker.sv
module fwl_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              img_rd_en,
  input logic [ADDR_W-1:0] img_addr,
  input logic [31:0]       img_limit,
  input logic              limit_ok,
  input logic              wr_en,
  input logic [7:0]        wr_reg,
  input logic [31:0]       wr_data,
  input logic              busy,
  input logic              done,
  input logic              fail
);

  p_trap_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_reg >= 8'h10) |-> (wr_data != 32'd0));

  p_reset_then_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_reg == 8'h01) |-> ($past(wr_en) && $past(wr_reg) == 8'h00));

  p_split_one_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_reg == 8'h01) |-> (wr_data[31:1] == 31'd0));

  p_read_in_bounds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (img_rd_en && limit_ok) |-> (32'(img_addr) < img_limit));

  p_write_while_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_fail_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !fail);

  p_done_fail_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

endmodule

bind fw_image_loader fwl_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .img_rd_en (img_rd_en),
  .img_addr  (img_addr),
  .img_limit (img_limit),
  .limit_ok  (limit_ok),
  .wr_en     (wr_en),
  .wr_reg    (wr_reg),
  .wr_data   (wr_data),
  .busy      (busy),
  .done      (done),
  .fail      (fail)
);

// File: tb/tb_fw_image_loader.sv
module tb_fw_image_loader;

  localparam int ADDR_W = 16;
  localparam int PROC_W = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] cfg_model = 16'h1234;
  logic [7:0]  cfg_major = 8'd2;
  logic [7:0]  cfg_minor = 8'd1;
  logic img_rd_en;
  logic [ADDR_W-1:0] img_addr;
  logic [7:0] img_rdata;
  logic wr_en;
  logic [PROC_W-1:0] wr_proc;
  logic [7:0] wr_reg;
  logic [31:0] wr_data;
  logic busy, done, fail;
  logic [2:0] err_code;

  always #2 clk = ~clk;

  fw_image_loader dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_model(cfg_model), .cfg_major(cfg_major), .cfg_minor(cfg_minor),
    .img_rd_en(img_rd_en), .img_addr(img_addr), .img_rdata(img_rdata),
    .wr_en(wr_en), .wr_proc(wr_proc), .wr_reg(wr_reg), .wr_data(wr_data),
    .busy(busy), .done(done), .fail(fail), .err_code(err_code)
  );

  logic [7:0] mem [0:511];
  always @(posedge clk) if (img_rd_en) img_rdata <= mem[img_addr[8:0]];

  int tests = 0;
  int fails = 0;
  int exp_n, act_n, cur_len, viol;
  logic [7:0]  exp_reg  [0:127];
  logic [7:0]  exp_proc [0:127];
  logic [31:0] exp_data [0:127];
  logic [7:0]  act_reg  [0:127];
  logic [7:0]  act_proc [0:127];
  logic [31:0] act_data [0:127];

  always @(negedge clk) begin
    if (wr_en && act_n < 128) begin
      act_reg[act_n]  = wr_reg;
      act_proc[act_n] = 8'(wr_proc);
      act_data[act_n] = wr_data;
      act_n = act_n + 1;
    end
    if (img_rd_en && 32'(img_addr) >= 32'(cur_len)) viol = viol + 1;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put32(input int a, input logic [31:0] v);
    mem[a] = v[31:24]; mem[a+1] = v[23:16]; mem[a+2] = v[15:8]; mem[a+3] = v[7:0];
  endtask

  task automatic exp_add(input int p, input logic [7:0] r, input logic [31:0] d);
    exp_reg[exp_n] = r; exp_proc[exp_n] = 8'(p); exp_data[exp_n] = d; exp_n++;
  endtask

  function automatic logic [31:0] word_val(input int p, input int k);
    return {8'(8'h11 + k), 8'(8'h40 + p), 8'(8'h90 + 3 * k), 8'(8'hC5 ^ k)};
  endfunction

  function automatic logic [31:0] trap_val(input int p, input int i);
    return {8'(8'h80 + i), 8'(p), 8'h5A, 8'(i + 1)};
  endfunction

  // descriptors at 16+80p: traps 4i, error-control +64, iram start +68, count +72, code offset +76
  task automatic build(input int np, input int nw, input logic [15:0] tmask,
                       input logic [15:0] model, input logic [7:0] maj, input logic [7:0] mn,
                       input int cnt_field, input logic [23:0] tag, input int len_ovr);
    int len;
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    exp_n = 0;
    exp_add(0, 8'h00, 32'd1);
    exp_add(0, 8'h01, (np > 1) ? 32'd1 : 32'd0);
    for (int p = 0; p < np; p++) begin
      int base = 16 + 80 * p;
      int coff = 176 + 64 * p;
      logic [31:0] ioff = 32'h200 + 32'(p) * 32'h40;
      put32(base + 64, 32'hECC00000 | 32'(p));
      put32(base + 68, ioff);
      put32(base + 72, 32'(nw));
      put32(base + 76, 32'(coff));
      exp_add(p, 8'h02, ioff);
      for (int k = 0; k < nw; k++) begin
        put32(coff + 4 * k, word_val(p, k));
        exp_add(p, 8'h03, word_val(p, k));
      end
      for (int i = 0; i < 16; i++) begin
        if (tmask[i]) begin
          put32(base + 4 * i, trap_val(p, i));
          exp_add(p, 8'h10 + 8'(i), trap_val(p, i));
        end
      end
      exp_add(p, 8'h04, 32'hECC00000 | 32'(p));
    end
    len = 176 + 64 * (np - 1) + 4 * nw + 4;
    if (len_ovr != 0) len = len_ovr;
    put32(0, 32'(len));
    mem[4] = tag[23:16]; mem[5] = tag[15:8]; mem[6] = tag[7:0];
    mem[7] = 8'd1;
    mem[8] = model[15:8]; mem[9] = model[7:0];
    mem[10] = maj; mem[11] = mn;
    mem[12] = 8'(cnt_field);
    cur_len = len;
  endtask

  task automatic run_load(output logic d, output logic f, output logic [2:0] e);
    act_n = 0;
    viol = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    d = 1'b0; f = 1'b0; e = 3'd0;
    for (int c = 0; c < 20000; c++) begin
      if (done || fail) break;
      @(negedge clk);
    end
    d = done; f = fail; e = err_code;
    chk(!(done && fail), "R10 done/fail together", {30'd0, done, fail}, 32'd0);
    @(negedge clk);
    chk(!done && !fail, "R10 single-cycle pulse", {30'd0, done, fail}, 32'd0);
    chk(err_code == e, "R10 err_code held", 32'(err_code), 32'(e));
    chk(viol == 0, "R9 read at or past length", 32'(viol), 32'd0);
  endtask

  task automatic cmp_writes();
    string tag;
    chk(act_n == exp_n, "R5 write count", 32'(act_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < act_n; i++) begin
      case (exp_reg[i])
        8'h00, 8'h04: tag = "R5 write";
        8'h01: tag = "R6 split write";
        8'h02, 8'h03: tag = "R1,R8 microcode write";
        default: tag = "R7 trap write";
      endcase
      chk(act_reg[i] == exp_reg[i], {tag, " reg"}, 32'(act_reg[i]), 32'(exp_reg[i]));
      chk(act_proc[i] == exp_proc[i], {tag, " proc"}, 32'(act_proc[i]), 32'(exp_proc[i]));
      chk(act_data[i] == exp_data[i], {tag, " data"}, act_data[i], exp_data[i]);
    end
  endtask

  task automatic expect_ok();
    logic d, f;
    logic [2:0] e;
    run_load(d, f, e);
    chk(d && !f && e == 3'd0, "R10 success completion", {28'd0, d, f, 2'd0} | 32'(e), 32'h8);
    cmp_writes();
  endtask

  task automatic expect_err(input logic [2:0] code, input string req);
    logic d, f;
    logic [2:0] e;
    run_load(d, f, e);
    chk(f && !d, {req, " fail pulse"}, {30'd0, d, f}, 32'd1);
    chk(e == code, {req, " error code"}, 32'(e), 32'(code));
    cmp_writes();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] masks [0:2];
    masks[0] = 16'hFFFF; masks[1] = 16'h0000; masks[2] = 16'hA5C3;
    act_n = 0; viol = 0; cur_len = 0;
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !fail && !wr_en && err_code == 3'd0 && !img_rd_en,
        "R10 reset state", {26'd0, busy, done, fail, wr_en, img_rd_en, |err_code}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R6 R7 R8: sweep processors, word counts and trap masks (R3 wildcard for one processor)
    for (int np = 1; np <= 2; np++)
      for (int nw = 0; nw <= 3; nw++)
        for (int m = 0; m < 3; m++) begin
          build(np, nw, masks[m], (np == 1) ? 16'h0000 : 16'h1234, 8'd2, 8'd1, np, 24'h514546, 0);
          expect_ok();
        end

    // R2: wrong tag
    build(1, 2, 16'hFFFF, 16'h0000, 8'd0, 8'd0, 1, 24'h514547, 0);
    exp_n = 0;
    expect_err(3'd1, "R2");

    // R3: device mismatch on minor and on model
    build(1, 2, 16'hFFFF, 16'h1234, 8'd2, 8'd0, 1, 24'h514546, 0);
    exp_n = 0;
    expect_err(3'd2, "R3");
    build(1, 2, 16'hFFFF, 16'h1235, 8'd2, 8'd1, 1, 24'h514546, 0);
    exp_n = 0;
    expect_err(3'd2, "R3");

    // R4: bad counts
    build(1, 1, 16'h0001, 16'h0000, 8'd0, 8'd0, 0, 24'h514546, 0);
    exp_n = 0;
    expect_err(3'd4, "R4");
    build(2, 1, 16'h0001, 16'h0000, 8'd0, 8'd0, 3, 24'h514546, 0);
    exp_n = 0;
    expect_err(3'd4, "R4");

    // R9: length cuts into word 2 of the microcode: reset, split, start address, words 0 and 1
    build(1, 4, 16'hFFFF, 16'h0000, 8'd0, 8'd0, 1, 24'h514546, 186);
    exp_n = 5;
    expect_err(3'd3, "R9");

    // R9: length cuts into the header
    build(1, 1, 16'hFFFF, 16'h0000, 8'd0, 8'd0, 1, 24'h514546, 10);
    exp_n = 0;
    expect_err(3'd3, "R9");

    // recovery after errors: R10 error cleared, full two-processor load
    build(2, 3, 16'h8001, 16'h1234, 8'd2, 8'd1, 2, 24'h514546, 0);
    expect_ok();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule